// File: doc/BRIEF.md
# Serial Control-Register Slave with Clamped Measurement Readback

This block gives a host access to a small bank of 8-bit control registers over a four-wire serial link made up of a clock, an active-low select, host-to-device data and device-to-host data. Every frame opens with a direction bit and a 7-bit address. A write frame then carries one data byte. A read frame instead returns the selected register's byte on the device-to-host line, together with an output enable so that the pad can release the line when the block is not driving it. The register fields leave the block as parallel outputs that control the analog side of the device.

The serial pins are sampled in the block's own system clock, which must run several times faster than the serial clock. The edges of the serial clock are detected after a short synchronizer. One register location does not hold stored data in its upper five bits. Those bits show a live 5-bit measurement taken from an input port, and the value shown is limited to the range 0 to 25.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, register 00h, 02h, 04h and the writable bits [2:0] of register 03h read as 0. Register 01h reads as 8'h64, which means drive swing 3'b011 and drive offset 3'b001.
- R2: A frame with first bit 0 is a write. It carries the address as 7 bits, MSB first, then the data as 8 bits, MSB first, all captured on rising serial clock edges while select is low. The register takes the data once the 16th rising edge has been seen.
- R3: During a write frame, the MISO output enable stays low the whole time.
- R4: A frame with first bit 1 is a read. The register is sampled just after the 8th rising edge. MISO is enabled from the falling edge of the 8th clock and carries the 8 bits MSB first, each one changing on a falling edge, so that the host can sample them on rising edges 9 to 16.
- R5: The fields map to outputs as follows. Register 00h bit 2 drives the extended-reach enable. Register 01h bits [7:5] drive the swing and bits [4:2] drive the offset. Register 02h bit 7 drives the coarse gain select and bits [6:3] drive the fine gain.
- R6: Register 03h bits [7:3] read back the measurement input, clamped to 25 when the input is above 25. Writes cannot change these bits. Bits [2:0] of register 03h are writable.
- R7: The implemented addresses are 00h to 04h. A write to any other address changes no register, and a read from any other address returns 8'h00.
- R8: When select rises before a write frame is complete, the partial write is discarded. When select rises, the MISO enable drops within a few system clocks.
- R9: Serial clocks beyond the 16th in a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_ss_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Host-to-device serial data |
| spi_miso | output | 1 | Device-to-host serial data |
| spi_miso_oe | output | 1 | High while the block drives spi_miso |
| meas_in | input | 5 | Live measurement value shown in register 03h |
| mode_reg | output | 8 | Register 00h contents |
| ext_reach_en | output | 1 | Extended-reach enable (register 00h bit 2) |
| drv_swing | output | 3 | Output swing code (register 01h [7:5]) |
| drv_offset | output | 3 | Output offset code (register 01h [4:2]) |
| amp_coarse | output | 1 | Coarse input gain select (register 02h bit 7) |
| amp_fine | output | 4 | Fine input gain trim (register 02h [6:3]) |
| aux_reg | output | 8 | Register 04h contents |

## Verification
The assertions check on every cycle that:
- the MISO enable stays low outside read frames and drops once select is released;
- out-of-range addresses read as zero and never disturb a field;
- the measurement view never goes above 25 and follows inputs within range;
- the fields hold their defaults in the first cycle after reset;
- a write commits only inside a write frame.

Only the bench's scenarios can show the bit order and the edge alignment of read data on MISO, that write data lands in the correct fields, and that aborted frames and extra clocks leave the registers intact, because each of these depends on a full serial frame driven from the host side.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 5;
  localparam int MEAS_W    = 5;
  localparam int MEAS_MAX  = 25;
  localparam int MEAS_REG  = 3;
  localparam int MEAS_LSB  = DATA_W - MEAS_W;

  // Power-on value of each register location
  function automatic logic [DATA_W-1:0] reset_value(input int idx);
    case (idx)
      1:       return 8'h64;  // swing 3'b011, offset 3'b001
      default: return '0;
    endcase
  endfunction

  // Limit a raw measurement to the legal range
  function automatic logic [MEAS_W-1:0] clamp_meas(input logic [MEAS_W-1:0] raw);
    if (int'(raw) > MEAS_MAX) return MEAS_W'(MEAS_MAX);
    return raw;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ss_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic ss_act,
  output logic mosi_s
);
  logic [STAGES:0]   sck_sh;
  logic [STAGES-1:0] ss_sh;
  logic [STAGES-1:0] mosi_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh  <= '0;
      ss_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sck_sh  <= {sck_sh[STAGES-1:0], sck_i};
      ss_sh   <= {ss_sh[STAGES-2:0], ss_n_i};
      mosi_sh <= {mosi_sh[STAGES-2:0], mosi_i};
    end
  end

  assign sck_rise = sck_sh[STAGES-1] & ~sck_sh[STAGES];
  assign sck_fall = ~sck_sh[STAGES-1] & sck_sh[STAGES];
  assign ss_act   = ~ss_sh[STAGES-1];
  assign mosi_s   = mosi_sh[STAGES-1];
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              ss_act,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] frame_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_mode,
  output logic              rd_load,
  output logic              frame_abort,
  output logic              miso_q,
  output logic              miso_oe
);
  localparam int HDR   = 1 + ADDR_W;
  localparam int FRAME = HDR + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int SH_W  = (HDR > DATA_W) ? HDR : DATA_W;

  logic [CNT_W-1:0]  cnt;
  logic [SH_W-2:0]   shreg;
  logic [SH_W-1:0]   next_sh;
  logic [DATA_W-1:0] tx;
  logic              hdr_done;
  logic              data_done;
  logic              tx_slot;

  assign next_sh     = {shreg, mosi_s};
  assign hdr_done    = sck_rise && (cnt == CNT_W'(HDR - 1));
  assign data_done   = sck_rise && (cnt == CNT_W'(FRAME - 1)) && !rd_mode;
  assign tx_slot     = sck_fall && rd_mode && (cnt >= CNT_W'(HDR)) && (cnt < CNT_W'(FRAME));
  assign frame_abort = !ss_act && (cnt != '0) && (cnt < CNT_W'(FRAME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      shreg      <= '0;
      tx         <= '0;
      frame_addr <= '0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      rd_mode    <= 1'b0;
      rd_load    <= 1'b0;
      miso_q     <= 1'b0;
      miso_oe    <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      rd_load <= 1'b0;
      if (!ss_act) begin
        cnt     <= '0;
        rd_mode <= 1'b0;
        miso_oe <= 1'b0;
      end else begin
        if (sck_rise && (cnt < CNT_W'(FRAME))) begin
          shreg <= next_sh[SH_W-2:0];
          cnt   <= cnt + 1'b1;
        end
        if (hdr_done) begin
          rd_mode    <= next_sh[HDR-1];
          frame_addr <= next_sh[ADDR_W-1:0];
          rd_load    <= next_sh[HDR-1];
        end
        if (data_done) begin
          wr_en   <= 1'b1;
          wr_data <= next_sh[DATA_W-1:0];
        end
        if (rd_load) tx <= rd_data;
        else if (tx_slot) begin
          miso_q  <= tx[DATA_W-1];
          tx      <= {tx[DATA_W-2:0], 1'b0};
          miso_oe <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MEAS_W-1:0] meas_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [MEAS_W-1:0] meas_view,
  output logic [DATA_W-1:0] mode_reg,
  output logic [2:0]        drv_swing,
  output logic [2:0]        drv_offset,
  output logic              amp_coarse,
  output logic [3:0]        amp_fine,
  output logic [DATA_W-1:0] aux_reg
);
  logic [DATA_W-1:0] store [NUM_REGS];
  logic [DATA_W-1:0] view  [NUM_REGS];

  assign meas_view = clamp_meas(meas_in);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == MEAS_REG) begin : g_meas
      logic [MEAS_LSB-1:0] low_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= reset_value(g) >> 0;
        else if (wr_en && addr == ADDR_W'(g)) low_q <= wr_data[MEAS_LSB-1:0];
      end
      assign store[g] = {{MEAS_W{1'b0}}, low_q};
      assign view[g]  = {meas_view, low_q};
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_value(g);
        else if (wr_en && addr == ADDR_W'(g)) q <= wr_data;
      end
      assign store[g] = q;
      assign view[g]  = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rd_data = view[i];
  end

  assign mode_reg   = store[0];
  assign drv_swing  = store[1][7:5];
  assign drv_offset = store[1][4:2];
  assign amp_coarse = store[2][7];
  assign amp_fine   = store[2][6:3];
  assign aux_reg    = store[4];

  logic unused_ok;
  assign unused_ok = ^{store[1][1:0], store[2][2:0], store[3]};
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [MEAS_W-1:0] meas_in,
  output logic [DATA_W-1:0] mode_reg,
  output logic              ext_reach_en,
  output logic [2:0]        drv_swing,
  output logic [2:0]        drv_offset,
  output logic              amp_coarse,
  output logic [3:0]        amp_fine,
  output logic [DATA_W-1:0] aux_reg
);
  logic              sck_rise, sck_fall, ss_act, mosi_s;
  logic [ADDR_W-1:0] frame_addr;
  logic              wr_en, rd_mode, rd_load, frame_abort;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [MEAS_W-1:0] meas_view;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .ss_n_i(spi_ss_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .ss_act(ss_act), .mosi_s(mosi_s)
  );

  spi_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .ss_act(ss_act), .mosi_s(mosi_s), .rd_data(rd_data), .frame_addr(frame_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_mode(rd_mode), .rd_load(rd_load),
    .frame_abort(frame_abort), .miso_q(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(frame_addr), .wr_data(wr_data),
    .meas_in(meas_in), .rd_data(rd_data), .meas_view(meas_view), .mode_reg(mode_reg),
    .drv_swing(drv_swing), .drv_offset(drv_offset), .amp_coarse(amp_coarse),
    .amp_fine(amp_fine), .aux_reg(aux_reg)
  );

  assign ext_reach_en = mode_reg[2];
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_regs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ss_act,
  input logic              rd_mode,
  input logic              rd_load,
  input logic              wr_en,
  input logic              frame_abort,
  input logic [ADDR_W-1:0] frame_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [MEAS_W-1:0] meas_in,
  input logic [MEAS_W-1:0] meas_view,
  input logic              spi_miso_oe,
  input logic [DATA_W-1:0] mode_reg,
  input logic [2:0]        drv_swing,
  input logic [2:0]        drv_offset,
  input logic              amp_coarse,
  input logic [3:0]        amp_fine,
  input logic [DATA_W-1:0] aux_reg
);
  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mode_reg == 8'h00 && drv_swing == 3'b011 && drv_offset == 3'b001
                       && !amp_coarse && amp_fine == 4'h0 && aux_reg == 8'h00));
  // R2
  write_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ss_act && !rd_mode));
  // R3
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_act && !rd_mode) |-> !spi_miso_oe);
  // R4
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_oe) |-> (rd_mode && !rd_load));
  // R6
  meas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(meas_view) <= MEAS_MAX);
  // R6
  meas_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(meas_in) <= MEAS_MAX) |-> meas_view == meas_in);
  // R7
  bad_addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(frame_addr) >= NUM_REGS) |-> rd_data == '0);
  // R7
  bad_addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(frame_addr) >= NUM_REGS) |=>
      $stable({mode_reg, drv_swing, drv_offset, amp_coarse, amp_fine, aux_reg}));
  // R8
  release_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> !spi_miso_oe);
  // R8
  abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !wr_en);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ss_act(ss_act), .rd_mode(rd_mode), .rd_load(rd_load),
  .wr_en(wr_en), .frame_abort(frame_abort), .frame_addr(frame_addr), .rd_data(rd_data),
  .meas_in(meas_in), .meas_view(meas_view), .spi_miso_oe(spi_miso_oe),
  .mode_reg(mode_reg), .drv_swing(drv_swing), .drv_offset(drv_offset),
  .amp_coarse(amp_coarse), .amp_fine(amp_fine), .aux_reg(aux_reg)
);

// File: tb/spi_reg_slave_bench.sv
`timescale 1ns/1ps
module spi_reg_slave_bench;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe;
  logic [4:0] meas_in = 5'd0;
  logic [7:0] mode_reg, aux_reg;
  logic       ext_reach_en, amp_coarse;
  logic [2:0] drv_swing, drv_offset;
  logic [3:0] amp_fine;

  int checks = 0, errors = 0;
  bit cmp_en = 0, in_write = 0, done = 0;
  int model [5];
  int m3_low;

  always #2.5 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .meas_in(meas_in),
    .mode_reg(mode_reg), .ext_reach_en(ext_reach_en), .drv_swing(drv_swing),
    .drv_offset(drv_offset), .amp_coarse(amp_coarse), .amp_fine(amp_fine), .aux_reg(aux_reg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int expect_read(input int addr);
    int shown;
    if (addr > 4) return 0;
    if (addr != 3) return model[addr];
    shown = (meas_in > 5'd25) ? 25 : int'(meas_in);
    return shown * 8 + m3_low;
  endfunction

  // Per-clock comparison of field outputs with the reference registers (R5)
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(mode_reg == 8'(model[0]), "R5 mode_reg", mode_reg, model[0]);
      check(ext_reach_en == model[0][2], "R5 ext_reach_en", ext_reach_en, model[0][2]);
      check({drv_swing, drv_offset} == 6'(model[1] >> 2), "R5 swing/offset",
            {drv_swing, drv_offset}, model[1] >> 2);
      check({amp_coarse, amp_fine} == 5'(model[2] >> 3), "R5 coarse/fine",
            {amp_coarse, amp_fine}, model[2] >> 3);
      check(aux_reg == 8'(model[4]), "R5 aux_reg", aux_reg, model[4]);
    end
    if (rst_n && in_write) check(!spi_miso_oe, "R3 oe in write", spi_miso_oe, 0);
  end

  task automatic xfer(input logic [15:0] w, input int nbits, input int keep_ss,
                      output logic [7:0] rb);
    rb = '0;
    cmp_en = 0;
    in_write = !w[15];
    @(posedge clk); #1 spi_ss_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      #1 spi_mosi = (i < 16) ? w[15 - i] : 1'b1;
      repeat (HALF) @(posedge clk);
      #1 spi_sck = 1'b1;
      if (w[15] && i == 7) check(!spi_miso_oe, "R4 oe before data", spi_miso_oe, 0);
      if (w[15] && i >= 8 && i < 16) begin
        check(spi_miso_oe, "R4 oe during data", spi_miso_oe, 1);
        rb[15 - i] = spi_miso;
      end
      repeat (HALF) @(posedge clk);
      #1 spi_sck = 1'b0;
    end
    repeat (keep_ss) @(posedge clk);
    #1 spi_ss_n = 1'b1;
    in_write = 0;
    repeat (8) @(posedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    logic [7:0] d;
    xfer({1'b0, 7'(addr), 8'(data)}, 16, 4, d);
    if (addr < 5 && addr != 3) model[addr] = data & 8'hFF;
    if (addr == 3) m3_low = data & 7;
    cmp_en = 1;
  endtask

  task automatic rd(input int addr, input string req);
    logic [7:0] d;
    xfer({1'b1, 7'(addr), 8'h00}, 16, 4, d);
    check(d == 8'(expect_read(addr)), req, d, expect_read(addr));
    cmp_en = 1;
  endtask

  initial begin
    logic [7:0] junk;
    model[0] = 0; model[1] = 8'h64; model[2] = 0; model[3] = 0; model[4] = 0; m3_low = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check(mode_reg == 8'h00, "R1 mode_reg", mode_reg, 0);
    check(drv_swing == 3'b011, "R1 swing", drv_swing, 3);
    check(drv_offset == 3'b001, "R1 offset", drv_offset, 1);
    check({amp_coarse, amp_fine} == 5'd0, "R1 gain", {amp_coarse, amp_fine}, 0);
    check(aux_reg == 8'h00, "R1 aux", aux_reg, 0);
    check(!spi_miso_oe, "R1 oe idle", spi_miso_oe, 0);
    cmp_en = 1;
    rd(1, "R1 R4 read default reg1");
    rd(3, "R1 read default reg3");
    // R2 R5 writes to each field
    wr(1, 8'hA9); rd(1, "R2 readback reg1");
    wr(0, 8'h04); rd(0, "R2 readback reg0");
    wr(2, 8'hF8); rd(2, "R2 readback reg2");
    wr(4, 8'h3C); rd(4, "R4 readback reg4");
    wr(2, 8'h53); rd(2, "R5 reg2 pattern");
    // R6 measurement view and its clamp
    meas_in = 5'd31; rd(3, "R6 clamp at 25");
    wr(3, 8'hFF); rd(3, "R6 upper bits read-only");
    meas_in = 5'd7; rd(3, "R6 follow in-range value");
    meas_in = 5'd25; rd(3, "R6 top legal value");
    // R7 unimplemented addresses
    wr(9, 8'hFF); rd(9, "R7 read addr 09h");
    wr(7'h7F, 8'h00); rd(7'h7F, "R7 read addr 7Fh");
    // R8 aborted write, then aborted read
    xfer({1'b0, 7'd4, 8'hFF}, 10, 4, junk);
    cmp_en = 1;
    rd(4, "R8 aborted write discarded");
    xfer({1'b1, 7'd1, 8'h00}, 12, 0, junk);
    check(!spi_miso_oe, "R8 oe released", spi_miso_oe, 0);
    cmp_en = 1;
    // R9 extra clocks ignored
    xfer({1'b0, 7'd0, 8'h55}, 20, 4, junk);
    model[0] = 8'h55;
    cmp_en = 1;
    rd(0, "R9 extra clocks ignored");
    repeat (10) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule